// File: doc/BRIEF.md
# Closest-Ratio Clock Divider Search Engine

This block works out the numerator/denominator pair for a fractional clock divider. Given a source clock frequency and a wanted master clock frequency, both in hertz, it searches for the numerator (FRACT) and denominator (DIVIDE) whose ratio comes closest to the target. When it finishes it returns both values already reduced by one, ready for a divider configuration field, together with the residual error of the chosen pair.

The search runs sequentially. Both frequencies are first scaled down by 100 so that later products stay within range. A bound on the numerator is then derived from the frequency ratio. Numerators are tried in increasing order. Each one costs one multi-cycle restoring division of `source*FRACT` by the target. A remainder is rounded to the nearer quotient. The best candidate so far is replaced only by a strictly better one, and an exact match stops the scan at once. All divisions, including the prescale and the bound, share a single iterative divider.

A caller pulses `start` with both frequencies valid, waits for `busy` to fall, and reads the result on the single-cycle `done` pulse. An `err` pulse takes its place when the scaled target is zero.

Top module: `mclk_ratio_search`

## Requirements
- R1: On an accepted start, both frequencies are replaced by their integer quotients by 100 (floor), and every later step uses these scaled values S (source) and T (target).
- R2: The scan limit is L = min(floor(T*4096/S) + 1, 256), and the numerators tried are 1, 2, ..., L-1 in increasing order. No numerator at or beyond L is tried.
- R3: For numerator F the engine forms q = floor(S*F/T) and r = S*F mod T. If r > floor(T/2), the candidate becomes (q+1, T-r); otherwise it is (q, r).
- R4: A candidate replaces the best pair only when its rounded remainder is strictly smaller. On equal remainders the earlier, smaller numerator is kept. The first candidate always wins against the initial best remainder of all ones.
- R5: A candidate with r = 0 ends the scan immediately. The result is that numerator and quotient, and best_rem is 0.
- R6: On done, fract_enc equals F-1 in FR_W bits, div_enc equals the low DIV_W bits of q-1, and best_rem holds the rounded remainder of the chosen pair. If no numerator was tried (L <= 1), fract_enc and div_enc are all ones and best_rem is all ones.
- R7: If T is 0, the engine raises err for one cycle, does not raise done, and leaves fract_enc, div_enc and best_rem unchanged.
- R8: busy is high from the cycle after an accepted start until the cycle in which done or err is high, where it is low. A start while busy is ignored, and the result reflects only the accepted inputs.
- R9: done is a one-cycle pulse. fract_enc, div_enc and best_rem change only in a cycle where done is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a search with the present frequencies (ignored while busy) |
| src_hz | input | FREQ_W | Source clock frequency in Hz |
| tgt_hz | input | FREQ_W | Wanted master clock frequency in Hz |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle pulse: result fields updated |
| err | output | 1 | One-cycle pulse: scaled target was zero, no result |
| fract_enc | output | FR_W | Chosen numerator minus one |
| div_enc | output | DIV_W | Chosen denominator minus one |
| best_rem | output | FREQ_W | Rounded remainder of the chosen pair |

## Verification
The bench aims at the corners of the scan. The first is a tie between two numerators, where an engine using a less-or-equal comparison would report the later numerator. The second is a scan whose limit sits just below an exact match, which an off-by-one bound would find. The third is a remainder just above half the target, which a design without rounding would leave un-incremented. It also covers a bound of one, where nothing is tried and every field must read all ones, and a target under 100 Hz, which must give err with the old fields intact. A start pulsed mid-search must not disturb the running search. Using a source frequency whose last two digits are non-zero exposes a prescale that rounds instead of truncating.

// File: rtl/mclk_ratio_pkg.sv
// Shared types for the closest-ratio divider search engine.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package mclk_ratio_pkg;

    // Sequencer states of the search engine
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE_SRC,
        ST_PRE_TGT,
        ST_LIMIT,
        ST_CAND
    } srch_state_t;

endpackage

// File: rtl/mrs_restoring_div.sv
// Iterative restoring divider: one quotient bit per cycle, W cycles per divide.
// Assumes: go is a single-cycle pulse and is not raised while a divide runs.
// A zero divisor yields an all-ones quotient and is harmless.
module mrs_restoring_div #(
    parameter int W = 40
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         fin,
    output logic [W-1:0] quo,
    output logic [W-1:0] rem
);
    localparam int CNT_W = $clog2(W);

    logic             run;
    logic [CNT_W-1:0] cnt;
    logic [W-1:0]     acc;
    logic [W-1:0]     sh;
    logic [W:0]       trial;
    logic             take;

    // Trial subtraction for the current bit
    always_comb begin
        trial = {acc, sh[W-1]};
        take  = (trial >= {1'b0, divisor});
    end

    // Shift/subtract iteration and completion pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run <= 1'b0;
            fin <= 1'b0;
            cnt <= '0;
            acc <= '0;
            sh  <= '0;
        end else begin
            fin <= 1'b0;
            if (go) begin
                sh  <= dividend;
                acc <= '0;
                cnt <= CNT_W'(W - 1);
                run <= 1'b1;
            end else if (run) begin
                acc <= take ? W'(trial - {1'b0, divisor}) : trial[W-1:0];
                sh  <= {sh[W-2:0], take};
                if (cnt == '0) begin
                    run <= 1'b0;
                    fin <= 1'b1;
                end else begin
                    cnt <= cnt - CNT_W'(1);
                end
            end
        end
    end

    assign quo = sh;
    assign rem = acc;

endmodule

// File: rtl/mrs_cand_eval.sv
// Candidate evaluator: rounds a quotient/remainder pair to the nearer
// quotient and compares the rounded remainder with the best one so far.
// Assumes: rem < tgt (true for any remainder of a division by tgt).
module mrs_cand_eval #(
    parameter int DVD_W  = 40,
    parameter int FREQ_W = 32
) (
    input  logic [DVD_W-1:0]  quo,
    input  logic [DVD_W-1:0]  rem,
    input  logic [FREQ_W-1:0] tgt,
    input  logic [FREQ_W-1:0] best,
    output logic              exact,
    output logic              better,
    output logic [DVD_W-1:0]  adj_q,
    output logic [FREQ_W-1:0] adj_r
);
    logic [DVD_W-1:0] half;

    // Round to nearest and rank against the current best
    always_comb begin
        half  = DVD_W'(tgt >> 1);
        exact = (rem == '0);
        if (rem > half) begin
            adj_q = quo + DVD_W'(1);
            adj_r = FREQ_W'(DVD_W'(tgt) - rem);
        end else begin
            adj_q = quo;
            adj_r = FREQ_W'(rem);
        end
        better = (adj_r < best);
    end

endmodule

// File: rtl/mclk_ratio_search.sv
// Closest-ratio divider search engine (top).
// Prescales both frequencies, derives the numerator bound, then scans
// numerators 1..L-1 with one shared restoring divider, keeping the pair
// with the smallest rounded remainder. Results are reported minus one.
// Assumes: inputs are sampled only on an accepted start; src_hz >= 100.
module mclk_ratio_search
    import mclk_ratio_pkg::*;
#(
    parameter int FREQ_W    = 32,
    parameter int DVD_W     = 40,
    parameter int FR_W      = 8,
    parameter int DIV_W     = 16,
    parameter int PRESCALE  = 100,
    parameter int LIM_SHIFT = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [FREQ_W-1:0] src_hz,
    input  logic [FREQ_W-1:0] tgt_hz,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [FR_W-1:0]   fract_enc,
    output logic [DIV_W-1:0]  div_enc,
    output logic [FREQ_W-1:0] best_rem
);
    localparam int                CNT_W  = FR_W + 1;
    localparam logic [CNT_W-1:0]  FR_CAP = CNT_W'(1) << FR_W;
    localparam logic [DVD_W-1:0]  Q_CAP  = DVD_W'(FR_CAP - CNT_W'(1));

    srch_state_t       state;
    logic [FREQ_W-1:0] t_raw;
    logic [FREQ_W-1:0] s_pre;
    logic [FREQ_W-1:0] t_pre;
    logic [CNT_W-1:0]  lim;
    logic [CNT_W-1:0]  fr;
    logic [CNT_W-1:0]  fr_inc;
    logic [CNT_W-1:0]  bf;
    logic [DVD_W-1:0]  bq;
    logic [FREQ_W-1:0] br;

    logic              dv_go;
    logic [DVD_W-1:0]  dv_dvd;
    logic [DVD_W-1:0]  dv_dsr;
    logic              dv_fin;
    logic [DVD_W-1:0]  dv_q;
    logic [DVD_W-1:0]  dv_r;

    logic              ev_exact;
    logic              ev_better;
    logic [DVD_W-1:0]  ev_q;
    logic [FREQ_W-1:0] ev_r;

    logic [CNT_W-1:0]  sel_f;
    logic [DVD_W-1:0]  sel_q;
    logic [FREQ_W-1:0] sel_r;
    logic [DVD_W-1:0]  prod_next;

    // Shared iterative divider
    mrs_restoring_div #(.W(DVD_W)) div_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (dv_go),
        .dividend (dv_dvd),
        .divisor  (dv_dsr),
        .fin      (dv_fin),
        .quo      (dv_q),
        .rem      (dv_r)
    );

    // Rounding and ranking of the finished candidate
    mrs_cand_eval #(.DVD_W(DVD_W), .FREQ_W(FREQ_W)) eval_i (
        .quo    (dv_q),
        .rem    (dv_r),
        .tgt    (t_pre),
        .best   (br),
        .exact  (ev_exact),
        .better (ev_better),
        .adj_q  (ev_q),
        .adj_r  (ev_r)
    );

    // Next best pair and next product
    always_comb begin
        fr_inc    = fr + CNT_W'(1);
        prod_next = DVD_W'(s_pre) * DVD_W'(fr_inc);
        if (ev_better) begin
            sel_f = fr;
            sel_q = ev_q;
            sel_r = ev_r;
        end else begin
            sel_f = bf;
            sel_q = bq;
            sel_r = br;
        end
    end

    // Search sequencer, divider launch and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            t_raw     <= '0;
            s_pre     <= '0;
            t_pre     <= '0;
            lim       <= '0;
            fr        <= '0;
            bf        <= '0;
            bq        <= '0;
            br        <= '1;
            dv_go     <= 1'b0;
            dv_dvd    <= '0;
            dv_dsr    <= '0;
            done      <= 1'b0;
            err       <= 1'b0;
            fract_enc <= '0;
            div_enc   <= '0;
            best_rem  <= '0;
        end else begin
            dv_go <= 1'b0;
            done  <= 1'b0;
            err   <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        t_raw  <= tgt_hz;
                        dv_dvd <= DVD_W'(src_hz);
                        dv_dsr <= DVD_W'(PRESCALE);
                        dv_go  <= 1'b1;
                        state  <= ST_PRE_SRC;
                    end
                end
                ST_PRE_SRC: begin
                    if (dv_fin) begin
                        s_pre  <= FREQ_W'(dv_q);
                        dv_dvd <= DVD_W'(t_raw);
                        dv_dsr <= DVD_W'(PRESCALE);
                        dv_go  <= 1'b1;
                        state  <= ST_PRE_TGT;
                    end
                end
                ST_PRE_TGT: begin
                    if (dv_fin) begin
                        t_pre <= FREQ_W'(dv_q);
                        if (dv_q == '0) begin
                            err   <= 1'b1;
                            state <= ST_IDLE;
                        end else begin
                            dv_dvd <= DVD_W'(FREQ_W'(dv_q)) << LIM_SHIFT;
                            dv_dsr <= DVD_W'(s_pre);
                            dv_go  <= 1'b1;
                            state  <= ST_LIMIT;
                        end
                    end
                end
                ST_LIMIT: begin
                    if (dv_fin) begin
                        bf <= '0;
                        bq <= '0;
                        br <= '1;
                        fr <= CNT_W'(1);
                        if (dv_q >= Q_CAP) begin
                            lim <= FR_CAP;
                        end else begin
                            lim <= CNT_W'(dv_q) + CNT_W'(1);
                        end
                        if (dv_q == '0) begin
                            // bound of one: nothing to try
                            fract_enc <= '1;
                            div_enc   <= '1;
                            best_rem  <= '1;
                            done      <= 1'b1;
                            state     <= ST_IDLE;
                        end else begin
                            dv_dvd <= DVD_W'(s_pre);
                            dv_dsr <= DVD_W'(t_pre);
                            dv_go  <= 1'b1;
                            state  <= ST_CAND;
                        end
                    end
                end
                ST_CAND: begin
                    if (dv_fin) begin
                        if (ev_exact) begin
                            fract_enc <= FR_W'(fr - CNT_W'(1));
                            div_enc   <= DIV_W'(dv_q - DVD_W'(1));
                            best_rem  <= '0;
                            done      <= 1'b1;
                            state     <= ST_IDLE;
                        end else if (fr_inc >= lim) begin
                            fract_enc <= FR_W'(sel_f - CNT_W'(1));
                            div_enc   <= DIV_W'(sel_q - DVD_W'(1));
                            best_rem  <= sel_r;
                            done      <= 1'b1;
                            state     <= ST_IDLE;
                        end else begin
                            bf     <= sel_f;
                            bq     <= sel_q;
                            br     <= sel_r;
                            fr     <= fr_inc;
                            dv_dvd <= prod_next;
                            dv_dsr <= DVD_W'(t_pre);
                            dv_go  <= 1'b1;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy = (state != ST_IDLE);

endmodule

// File: rtl/mclk_ratio_search_chk.sv
// Protocol checker for the search engine, bound to the top module.
// Assumes: synchronous active-low reset on rst_n.
module mclk_ratio_search_chk #(
    parameter int FREQ_W = 32,
    parameter int FR_W   = 8,
    parameter int DIV_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic              err,
    input logic [FR_W-1:0]   fract_enc,
    input logic [DIV_W-1:0]  div_enc,
    input logic [FREQ_W-1:0] best_rem
);
    p_done_err_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && err));

    p_err_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !busy);

    p_start_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_hold_fract_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(fract_enc));

    p_hold_div_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(div_enc));

    p_hold_rem_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(best_rem));

endmodule

bind mclk_ratio_search mclk_ratio_search_chk #(
    .FREQ_W (FREQ_W),
    .FR_W   (FR_W),
    .DIV_W  (DIV_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .err       (err),
    .fract_enc (fract_enc),
    .div_enc   (div_enc),
    .best_rem  (best_rem)
);

// File: tb/mclk_ratio_search_tb_top.sv
// Scoreboard bench: the driver pushes expected results, the monitor pops
// and compares them whenever done or err appears.
module mclk_ratio_search_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] src_hz = '0;
    logic [31:0] tgt_hz = '0;
    logic        busy;
    logic        done;
    logic        err;
    logic [7:0]  fract_enc;
    logic [15:0] div_enc;
    logic [31:0] best_rem;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    typedef struct {
        bit          is_err;
        longint      f;
        longint      d;
        longint      r;
        string       tag;
    } exp_t;

    exp_t sb_q[$];
    longint last_f = 0;
    longint last_d = 0;
    longint last_r = 0;

    always #4 clk = ~clk;

    mclk_ratio_search dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .src_hz    (src_hz),
        .tgt_hz    (tgt_hz),
        .busy      (busy),
        .done      (done),
        .err       (err),
        .fract_enc (fract_enc),
        .div_enc   (div_enc),
        .best_rem  (best_rem)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Expected result computed from the requirement text
    function automatic exp_t model(input longint unsigned src, input longint unsigned tgt, input string tag);
        exp_t e;
        longint unsigned s, t, lim, cf, cq, cr, m, q, r;
        e.tag = tag;
        s = src / 100;
        t = tgt / 100;
        e.is_err = (t == 0);
        e.f = 0; e.d = 0; e.r = 0;
        if (e.is_err) return e;
        lim = (t * 4096) / s + 1;
        if (lim > 256) lim = 256;
        cf = 0; cq = 0; cr = 64'hFFFF_FFFF;
        for (longint unsigned f = 1; f < lim; f++) begin
            m = s * f;
            q = m / t;
            r = m % t;
            if (r == 0) begin
                cf = f; cq = q; cr = 0;
                break;
            end
            if (r > t / 2) begin
                r = t - r;
                q = q + 1;
            end
            if (r < cr) begin
                cf = f; cq = q; cr = r;
            end
        end
        e.f = longint'((cf - 1) & 64'hFF);
        e.d = longint'((cq - 1) & 64'hFFFF);
        e.r = longint'(cr & 64'hFFFF_FFFF);
        return e;
    endfunction

    // Driver: push expectation, issue start, optionally poke start mid-run
    task automatic run_case(input logic [31:0] s, input logic [31:0] t, input bit poke, input string tag);
        sb_q.push_back(model(s, t, tag));
        @(negedge clk);
        start  = 1'b1;
        src_hz = s;
        tgt_hz = t;
        @(negedge clk);
        start = 1'b0;
        check(busy === 1'b1, {tag, " R8 busy after start"}, busy, 1);
        if (poke) begin
            repeat (20) @(negedge clk);
            start  = 1'b1;
            src_hz = ~s;
            tgt_hz = t / 2 + 32'd777;
            @(negedge clk);
            start = 1'b0;
        end
        while (!(done || err)) @(negedge clk);
        @(negedge clk);
        check(busy === 1'b0, {tag, " R8 idle after result"}, busy, 0);
    endtask

    // Monitor: compare each result against the scoreboard head
    always @(negedge clk) begin
        if (rst_n && (done || err)) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R8 unexpected result", 1, 0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check(err == e.is_err, {e.tag, " R7 err flag"}, err, e.is_err);
                check(done == !e.is_err, {e.tag, " R9 done flag"}, done, !e.is_err);
                if (e.is_err) begin
                    check(fract_enc == last_f, {e.tag, " R7 fract kept"}, fract_enc, last_f);
                    check(div_enc == last_d, {e.tag, " R7 div kept"}, div_enc, last_d);
                    check(best_rem == last_r, {e.tag, " R7 rem kept"}, best_rem, last_r);
                end else begin
                    check(fract_enc == e.f, {e.tag, " R6 fract_enc"}, fract_enc, e.f);
                    check(div_enc == e.d, {e.tag, " R6 div_enc"}, div_enc, e.d);
                    check(best_rem == e.r, {e.tag, " R6 best_rem"}, best_rem, e.r);
                    last_f = e.f; last_d = e.d; last_r = e.r;
                end
            end
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected fewer than %0d", cycles, 150000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(busy == 1'b0, "R8 reset busy", busy, 0);
        check(done == 1'b0, "R9 reset done", done, 0);
        check(err == 1'b0, "R7 reset err", err, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R5: exact at first numerator, expect fract_enc 0, div_enc 3, rem 0
        run_case(32'd12_000_000, 32'd3_000_000, 1'b0, "R5 exact");
        check(fract_enc == 0 && div_enc == 3 && best_rem == 0, "R5 hand value", div_enc, 3);
        // R1/R3: S=10007 (floor of 10007.99), T=3, one candidate rounded up
        run_case(32'd1_000_799, 32'd399, 1'b0, "R1 R3 round-up");
        check(div_enc == 3335 && best_rem == 1, "R3 hand value", div_enc, 3335);
        // R2/R4: S=100000, T=60, L=3; tie at F=2 keeps F=1, F=3 not tried
        run_case(32'd10_000_000, 32'd6_000, 1'b0, "R2 R4 tie");
        check(fract_enc == 0 && div_enc == 1666 && best_rem == 20, "R4 hand value", fract_enc, 0);
        // R6: bound of one, nothing tried, all ones
        run_case(32'd500_000_000, 32'd100_000, 1'b0, "R6 empty");
        check(fract_enc == 8'hFF && div_enc == 16'hFFFF && best_rem == 32'hFFFF_FFFF,
              "R6 all ones", best_rem, 32'hFFFF_FFFF);
        // R7: scaled target zero
        run_case(32'd48_000_000, 32'd99, 1'b0, "R7 zero target");
        // R2/R3/R4: general scans
        run_case(32'd168_000_000, 32'd1_024_000, 1'b0, "R3 scan a");
        run_case(32'd172_000_000, 32'd1_024_000, 1'b0, "R4 scan b");
        run_case(32'd100_000, 32'd70_000, 1'b0, "R5 exact after ties");
        run_case(32'd48_000_000, 32'd12_288_000, 1'b0, "R2 scan c");
        // R8: start pulsed during a search is ignored
        run_case(32'd120_000_000, 32'd11_289_600, 1'b1, "R8 poke");
        run_case(32'd24_576_000, 32'd6_144_000, 1'b0, "R1 scan d");

        repeat (4) @(negedge clk);
        check(sb_q.size() == 0, "R9 scoreboard drained", sb_q.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule